// File: doc/BRIEF.md
# CPU Power Domain Shutdown Sequencer

This block takes up to three secondary CPU power domains down, one after another, when it sees a single start pulse. Each domain has a 7-bit control vector. The vector drives the domain's reset, isolation, clock gate, memory isolation and two staged power switches. Each domain also has an L1 memory power-down request.

For each domain the sequencer works in a fixed order:
1. It isolates the logic and then the memories.
2. It requests the L1 power-down and waits for the acknowledge.
3. It asserts reset, gates the clock and opens the main switch, then the second switch.
4. It waits until the domain's bit is low in both the primary and the secondary power status vectors. Only then does it move on to the next domain.

A one-cycle done pulse marks the end of the last domain. The switches, the memories and the status feedback are outside the block.

Top module: `cpu_pd_shutdown_seq`

## Requirements
- R1: After reset, every domain's control vector reads 0x4D: bit 0 reset_n=1, bit 1 iso=0, bit 2 main switch=1, bit 3 second switch=1, bit 4 clock off=0, bit 5 memory clock isolation=0, bit 6 memory isolation_n=1. In the same state l1_req, busy and done are all 0.
- R2: The control vector of domain d sits at pd_ctl[7*d+6 : 7*d]. Domain d's L1 request is l1_req[d] and its acknowledge is l1_ack[d].
- R3: A domain's isolation steps run in this order: iso bit set, then memory clock isolation bit set, then memory isolation_n bit cleared.
- R4: l1_req[d] rises only after all three isolation steps. Reset_n for that domain stays high until l1_ack[d] has been seen high, however long the acknowledge takes.
- R5: After the acknowledge, the domain's steps run in this order: reset_n cleared, clock off set, main switch cleared, second switch cleared.
- R6: The next domain is not touched, and done is not raised, until the current domain's bit is low in both sta_pri and sta_sec. A bit held high in either vector stalls the sequence.
- R7: Domain d's status bits are sta_pri[10+d] and sta_sec[10+d]. All other status bits have no effect.
- R8: Domains are processed in the order 0, 1, 2, and each domain completes before the next one starts.
- R9: done is a single-cycle pulse after the last domain reports off. busy is high from the cycle after the start pulse is taken until done.
- R10: A start pulse that arrives while busy is high is ignored. It causes no extra steps and no second done.
- R11: At most one bit of {l1_req, pd_ctl} changes in any clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to shut down all domains |
| l1_ack | input | NUM_DOM | L1 power-down acknowledge, one bit per domain |
| sta_pri | input | STA_W | Primary power status vector |
| sta_sec | input | STA_W | Secondary power status vector |
| pd_ctl | output | 7*NUM_DOM | Per-domain control vectors |
| l1_req | output | NUM_DOM | L1 power-down request, one bit per domain |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when all domains are off |

## Verification
Every control and request transition is logged, and the log is compared with the required per-domain order. The acknowledge and status delays are varied, from one cycle up to tens of cycles. This shows whether the block waits on the real handshakes or on a fixed time.

A second status-bit pattern holds one rail of a single domain high on purpose. This shows whether both rails are checked, and whether the right bit position is used. Unrelated status bits are also tied high, which shows whether the block decodes the status position correctly. A repeated start pulse in the middle of a sequence shows that start is ignored while busy.

// File: rtl/cpu_pd_shutdown_seq.sv
module cpu_pd_shutdown_seq #(
  parameter int NUM_DOM  = 3,
  parameter int STA_W    = 16,
  parameter int STA_BASE = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NUM_DOM-1:0]   l1_ack,
  input  logic [STA_W-1:0]     sta_pri,
  input  logic [STA_W-1:0]     sta_sec,
  output logic [NUM_DOM*7-1:0] pd_ctl,
  output logic [NUM_DOM-1:0]   l1_req,
  output logic                 busy,
  output logic                 done
);
  localparam int CW = 7;
  localparam int DW = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
  localparam int SW = (STA_W > 1) ? $clog2(STA_W) : 1;
  localparam int B_NRST = 0, B_ISO = 1, B_SW1 = 2, B_SW2 = 3;
  localparam int B_CKOFF = 4, B_MCKISO = 5, B_NMISO = 6;
  localparam logic [CW-1:0] ON_VAL = 7'b1001101;
  localparam logic [DW-1:0] LAST = DW'(NUM_DOM - 1);
  localparam int LAST_STA = STA_BASE + NUM_DOM - 1;

  typedef enum logic [3:0] {
    S_IDLE, S_ISO, S_MCKISO, S_MISO, S_L1REQ, S_L1WAIT,
    S_RST, S_CKOFF, S_SW1, S_SW2, S_WAITOFF
  } st_t;

  st_t st;
  logic [DW-1:0] dom;
  logic [NUM_DOM-1:0][CW-1:0] ctl;
  logic [NUM_DOM-1:0] req;
  logic [SW-1:0] sidx;
  logic dom_off;

  assign sidx    = SW'(STA_BASE) + SW'(dom);
  assign dom_off = !sta_pri[sidx] && !sta_sec[sidx];
  assign pd_ctl  = ctl;
  assign l1_req  = req;
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      dom  <= '0;
      ctl  <= {NUM_DOM{ON_VAL}};
      req  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:    if (start) begin st <= S_ISO; dom <= '0; end
        S_ISO:     begin ctl[dom][B_ISO]    <= 1'b1; st <= S_MCKISO; end
        S_MCKISO:  begin ctl[dom][B_MCKISO] <= 1'b1; st <= S_MISO;   end
        S_MISO:    begin ctl[dom][B_NMISO]  <= 1'b0; st <= S_L1REQ;  end
        S_L1REQ:   begin req[dom]           <= 1'b1; st <= S_L1WAIT; end
        S_L1WAIT:  if (l1_ack[dom]) st <= S_RST;
        S_RST:     begin ctl[dom][B_NRST]   <= 1'b0; st <= S_CKOFF;  end
        S_CKOFF:   begin ctl[dom][B_CKOFF]  <= 1'b1; st <= S_SW1;    end
        S_SW1:     begin ctl[dom][B_SW1]    <= 1'b0; st <= S_SW2;    end
        S_SW2:     begin ctl[dom][B_SW2]    <= 1'b0; st <= S_WAITOFF; end
        S_WAITOFF: if (dom_off) begin
          if (dom == LAST) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            dom <= dom + 1'b1;
            st  <= S_ISO;
          end
        end
        default:   st <= S_IDLE;
      endcase
    end
  end

  a_r11_single_change: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({req, ctl} ^ $past({req, ctl})) <= 1);

  a_r9_done_after_off: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!sta_pri[LAST_STA] && !sta_sec[LAST_STA]));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_chk
    a_r3_iso_before_l1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req[g]) |-> (ctl[g][B_ISO] && ctl[g][B_MCKISO] && !ctl[g][B_NMISO]));

    a_r4_rst_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl[g][B_NRST]) |-> (req[g] && $past(l1_ack[g])));

    a_r5_switch_order: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl[g][B_SW2]) |-> (!ctl[g][B_SW1] && ctl[g][B_CKOFF] && !ctl[g][B_NRST]));

    if (g > 0) begin : g_ord
      a_r8_prev_done_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl[g][B_ISO]) |-> !ctl[g-1][B_SW2]);
    end
  end
endmodule

// File: tb/test_cpu_pd_shutdown_seq.sv
module test_cpu_pd_shutdown_seq;
  localparam int N = 3;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] l1_ack;
  logic [SW-1:0] sta_pri, sta_sec;
  logic [N*7-1:0] pd_ctl;
  logic [N-1:0] l1_req;
  logic busy, done;

  cpu_pd_shutdown_seq #(.NUM_DOM(N), .STA_W(SW), .STA_BASE(10)) i_cpu_pd_shutdown_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .l1_ack(l1_ack),
    .sta_pri(sta_pri), .sta_sec(sta_sec), .pd_ctl(pd_ctl),
    .l1_req(l1_req), .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  int ack_dly = 1, pri_dly = 1, sec_dly = 1;
  logic [N-1:0] hold_pri = '0, hold_sec = '0;
  logic [SW-1:0] noise = '0;
  int ackc [N], pric [N], secc [N];

  always @(negedge clk) begin
    logic [SW-1:0] p, s;
    p = noise; s = noise;
    for (int d = 0; d < N; d++) begin
      if (l1_req[d]) ackc[d]++; else ackc[d] = 0;
      l1_ack[d] = l1_req[d] && (ackc[d] >= ack_dly);
      if (pd_ctl[7*d+2]) pric[d] = 0; else pric[d]++;
      if (pd_ctl[7*d+3]) secc[d] = 0; else secc[d]++;
      p[10+d] = hold_pri[d] || (pric[d] < pri_dly);
      s[10+d] = hold_sec[d] || (secc[d] < sec_dly);
    end
    sta_pri = p; sta_sec = s;
  end

  int ev_dom [512], ev_kind [512], ev_val [512];
  int ev_n = 0, multi = 0, done_n = 0;
  logic [N*8-1:0] prev_v;
  logic prev_rst = 1'b0;
  always @(negedge clk) begin
    logic [N*8-1:0] cur, diff;
    cur = {l1_req, pd_ctl};
    diff = cur ^ prev_v;
    if (rst_n && prev_rst) begin
      if ($countones(diff) > 1) multi++;
      for (int i = 0; i < N*8; i++)
        if (diff[i] && ev_n < 512) begin
          if (i >= N*7) begin ev_dom[ev_n] = i - N*7; ev_kind[ev_n] = 7; end
          else begin ev_dom[ev_n] = i / 7; ev_kind[ev_n] = i % 7; end
          ev_val[ev_n] = int'(cur[i]);
          ev_n++;
        end
      if (done) done_n++;
    end
    prev_v = cur;
    prev_rst = rst_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int c = 0;
    while (!done && c < 3000) begin @(negedge clk); c++; end
    check(done, req, int'(done), 1);
  endtask

  function automatic logic [6:0] dom_ctl(input int d);
    return pd_ctl[7*d +: 7];
  endfunction

  // R1 reset values
  task automatic t_reset();
    do_reset();
    for (int d = 0; d < N; d++)
      check(dom_ctl(d) == 7'h4D, "R1 reset ctl", int'(dom_ctl(d)), 'h4D);
    check(l1_req == 0 && !busy && !done, "R1 reset flags", int'({l1_req, busy, done}), 0);
  endtask

  // R2 R3 R4 R5 R8 R11 R9: full run, per-event order check
  task automatic t_full(input int a, input int p, input int s, input logic [SW-1:0] nz,
                        input string tag);
    int base, dn0, m0;
    int ek [8] = '{1, 5, 6, 7, 0, 4, 2, 3};
    int ev [8] = '{1, 1, 0, 1, 0, 1, 0, 0};
    ack_dly = a; pri_dly = p; sec_dly = s; noise = nz;
    do_reset();
    base = ev_n; dn0 = done_n; m0 = multi;
    pulse_start();
    check(busy, "R9 busy after start", int'(busy), 1);
    wait_done({"R9 done reached ", tag});
    check(!busy, "R9 busy low with done", int'(busy), 0);
    repeat (5) @(negedge clk);
    check(ev_n - base == N*8, {"R8 event count ", tag}, ev_n - base, N*8);
    if (ev_n - base == N*8)
      for (int j = 0; j < N*8; j++) begin
        int k = j % 8;
        string r = (k < 3) ? "R3" : (k == 3) ? "R4" : "R5";
        check(ev_dom[base+j] == j / 8, {"R8 domain order ", tag}, ev_dom[base+j], j / 8);
        check(ev_kind[base+j] == ek[k] && ev_val[base+j] == ev[k], {r, " step order ", tag},
              ev_kind[base+j] * 16 + ev_val[base+j], ek[k] * 16 + ev[k]);
      end
    for (int d = 0; d < N; d++)
      check(dom_ctl(d) == 7'h32, "R2 final ctl", int'(dom_ctl(d)), 'h32);
    check(l1_req == '1, "R2 final l1_req", int'(l1_req), (1 << N) - 1);
    check(done_n - dn0 == 1, "R9 one-cycle done", done_n - dn0, 1);
    check(multi == m0, "R11 single bit change", multi - m0, 0);
    noise = '0;
  endtask

  // R4 long acknowledge
  task automatic t_ack_wait();
    ack_dly = 30; pri_dly = 1; sec_dly = 1;
    do_reset();
    pulse_start();
    repeat (15) @(negedge clk);
    check(dom_ctl(0) == 7'h2F, "R4 reset held until ack", int'(dom_ctl(0)), 'h2F);
    check(l1_req[0], "R4 l1 request up", int'(l1_req[0]), 1);
    wait_done("R4 completes after ack");
    ack_dly = 1;
  endtask

  // R6 R7 status rails
  task automatic t_hold();
    int dn0;
    ack_dly = 1; pri_dly = 2; sec_dly = 2;
    do_reset();
    dn0 = done_n;
    hold_sec = 3'b001;
    pulse_start();
    repeat (60) @(negedge clk);
    check(dom_ctl(0) == 7'h32, "R6 dom0 switches open", int'(dom_ctl(0)), 'h32);
    check(dom_ctl(1) == 7'h4D && busy, "R6 dom1 untouched while sec bit 10 high",
          int'(dom_ctl(1)), 'h4D);
    hold_sec = '0; hold_pri = 3'b100;
    repeat (80) @(negedge clk);
    check(dom_ctl(2) == 7'h32, "R7 dom2 switches open", int'(dom_ctl(2)), 'h32);
    check(done_n == dn0 && busy, "R6 no done while pri bit 12 high", done_n - dn0, 0);
    hold_pri = '0;
    wait_done("R6 done after release");
  endtask

  // R10 start while busy
  task automatic t_restart();
    int base, dn0;
    ack_dly = 2; pri_dly = 3; sec_dly = 3;
    do_reset();
    base = ev_n; dn0 = done_n;
    pulse_start();
    repeat (8) @(negedge clk);
    pulse_start();
    wait_done("R10 done");
    repeat (60) @(negedge clk);
    check(done_n - dn0 == 1, "R10 single done", done_n - dn0, 1);
    check(ev_n - base == N*8, "R10 no extra steps", ev_n - base, N*8);
    check(!busy, "R10 idle after run", int'(busy), 0);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int d = 0; d < N; d++) begin ackc[d] = 0; pric[d] = 0; secc[d] = 0; end
    prev_v = '0;
    t_reset();
    t_full(1, 1, 1, '0, "fast");
    t_full(6, 2, 9, '0, "slow sec");
    t_full(3, 8, 2, 16'hE3FF, "R7 noise");
    t_ack_wait();
    t_hold();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule